// File: doc/BRIEF.md
# I2C Stuck-SDA Recovery Sequencer

This block takes control of a two-wire bus at power-up and runs a fixed recovery routine that frees a target whose serial interface came up in an undefined state and is pulling the data line low. Both lines are open-drain. A released line reads high through its pull-up. Driving a line low means asserting its output enable, and the pad output is tied to 0.

A start pulse begins an attempt. With both lines released, the sequencer waits out a long settling interval. It then toggles the clock line through a burst of pulses and leaves the clock released for a short while. Next it issues a start condition followed directly by a stop condition. Finally it releases the data line and reads it through a two-flop synchronizer. A high read ends the run with a pass. A low read repeats the whole attempt, up to a fixed number of retries.

After the last attempt the block always reports completion, even when every attempt has failed, so the rest of the boot flow is never held up. It does not carry normal bus transfers and it does not switch pin multiplexing. It only says that it has finished and whether the line came free.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, and whenever reset is asserted during a run, busy, done and pass read 0 and both output enables read 0.
- R2: A start pulse seen while idle raises busy on the next cycle and clears pass.
- R3: Each attempt begins with both lines released for SETTLE_CYC cycles. The clock enable is then low for UNIT_CYC cycles and high for UNIT_CYC cycles, PULSES times. The first clock-low drive appears SETTLE_CYC+UNIT_CYC+1 cycles after the start pulse is sampled.
- R4: After the burst, the clock stays released for 5*UNIT_CYC cycles. Then come five steps of UNIT_CYC cycles each: data released, data driven low (start condition), clock driven low, clock released, data released (stop condition). The data enable only changes while the clock enable is 0.
- R5: The data line is sampled through two flops. The decision is taken UNIT_CYC+2 cycles after the stop-condition release. A high sample ends the run with pass=1 and starts no further attempt.
- R6: A low sample repeats the full attempt, up to RETRIES extra attempts. Each attempt lasts SETTLE_CYC+30*UNIT_CYC+2 cycles, so done appears 1+N*(that length) cycles after the start is sampled, where N is the number of attempts.
- R7: If the sample is low on attempt RETRIES+1, the block still asserts done, with pass=0.
- R8: done is a single-cycle pulse, and busy is 0 in the cycle that done is 1.
- R9: pass keeps its value from the end of a run until the next accepted start.
- R10: A start pulse while busy has no effect: the number of attempts, the timing and the single done pulse are unchanged.
- R11: While not busy, both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the recovery run when idle |
| sda_i | input | 1 | Data line level read back from the pad |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | 1 when the data line read high at the end of the run |
| scl_oe_o | output | 1 | Clock line pull-low enable |
| sda_oe_o | output | 1 | Data line pull-low enable |

## Verification
The bench builds the block with UNIT_CYC=4, SETTLE_CYC=40, PULSES=10 and RETRIES=3. With these values one attempt takes 162 cycles, so a run that uses every retry finishes within a few hundred cycles. That makes it practical to drive a target model that holds the data line low for 0 to 6 attempts, which covers a pass on the first try, a pass on the last allowed try and complete failure. The short settle time also brings into reach a restart attempt partway through a run and a reset partway through a run.

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
  parameter int UNIT_CYC   = 4,
  parameter int SETTLE_CYC = 10000,
  parameter int PULSES     = 10,
  parameter int RETRIES    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_i,
  output logic busy_o,
  output logic done_o,
  output logic pass_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  localparam int HOLD_CYC = 5 * UNIT_CYC;
  localparam int TMAX     = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int PW       = $clog2(PULSES + 1);
  localparam int AW       = $clog2(RETRIES + 2);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETTLE, ST_PHI, ST_PLO, ST_HOLD,
    ST_SDAH, ST_SDAL, ST_SCLL, ST_SCLH, ST_STOP, ST_SAMP
  } st_t;

  st_t           st, nxt;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic [AW-1:0] att;
  logic [1:0]    sda_s;
  logic          done_q, pass_q;
  logic          last_att;

  function automatic logic [TW-1:0] dur(input st_t s);
    case (s)
      ST_SETTLE: dur = TW'(SETTLE_CYC - 1);
      ST_HOLD:   dur = TW'(HOLD_CYC - 1);
      ST_SAMP:   dur = TW'(1);
      ST_IDLE:   dur = '0;
      default:   dur = TW'(UNIT_CYC - 1);
    endcase
  endfunction

  assign last_att = (att == AW'(RETRIES));

  always_comb begin
    nxt = st;
    case (st)
      ST_SETTLE: nxt = ST_PHI;
      ST_PHI:    nxt = ST_PLO;
      ST_PLO:    nxt = (pcnt == PW'(PULSES - 1)) ? ST_HOLD : ST_PHI;
      ST_HOLD:   nxt = ST_SDAH;
      ST_SDAH:   nxt = ST_SDAL;
      ST_SDAL:   nxt = ST_SCLL;
      ST_SCLL:   nxt = ST_SCLH;
      ST_SCLH:   nxt = ST_STOP;
      ST_STOP:   nxt = ST_SAMP;
      ST_SAMP:   nxt = (sda_s[1] || last_att) ? ST_IDLE : ST_SETTLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      pcnt   <= '0;
      att    <= '0;
      sda_s  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sda_s  <= {sda_s[0], sda_i};
      if (st == ST_IDLE) begin
        if (start_i) begin
          st     <= ST_SETTLE;
          tmr    <= dur(ST_SETTLE);
          att    <= '0;
          pass_q <= 1'b0;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        st  <= nxt;
        tmr <= dur(nxt);
        if (st == ST_SETTLE) pcnt <= '0;
        if (st == ST_PLO)    pcnt <= pcnt + 1'b1;
        if (st == ST_SAMP) begin
          if (nxt == ST_IDLE) begin
            done_q <= 1'b1;
            pass_q <= sda_s[1];
          end else begin
            att <= att + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o   = (st != ST_IDLE);
  assign done_o   = done_q;
  assign pass_o   = pass_q;
  assign scl_oe_o = (st == ST_PLO) || (st == ST_SCLL);
  assign sda_oe_o = (st == ST_SDAL) || (st == ST_SCLL) || (st == ST_SCLH);

endmodule

module i2c_unstick_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic pass_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R11

  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_oe_o); // R4

  AST_STOP_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8

  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(pass_o)); // R9

  AST_PASS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> done_o); // R5

endmodule

bind i2c_unstick_seq i2c_unstick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pass_o(pass_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_unstick_seq_tb_top.sv
module i2c_unstick_seq_tb_top;
  localparam int U   = 4;
  localparam int S   = 40;
  localparam int P   = 10;
  localparam int RT  = 3;
  localparam int ATT = S + 30 * U + 2;
  localparam int NV  = 5;
  // stuck attempts, expected pass, expected attempts
  localparam int VEC [NV][3] = '{
    '{0, 1, 1}, '{1, 1, 2}, '{3, 1, 4}, '{4, 0, 4}, '{6, 0, 4}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, scl_oe, sda_oe, sda_in;
  int total = 0, bad = 0;
  int k_stuck = 0, seen = 0;
  int cyc, nscl, first_scl, hw, wmin, wmax, viol, last_fall, ndone, done_cyc, vdone;
  int busy1, pass1;
  logic p_scl, p_sda, p_done;

  always #2 clk = ~clk;

  assign sda_in = !sda_oe && (seen > k_stuck);

  i2c_unstick_seq #(.UNIT_CYC(U), .SETTLE_CYC(S), .PULSES(P), .RETRIES(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sda_i(sda_in), .busy_o(busy),
    .done_o(done), .pass_o(pass), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    cyc = 0; nscl = 0; first_scl = 0; hw = 0; wmin = 1 << 30; wmax = 0; viol = 0;
    last_fall = 0; ndone = 0; done_cyc = 0; vdone = 0; seen = 0;
    p_scl = 1'b0; p_sda = 1'b0; p_done = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (scl_oe && !p_scl) begin
      nscl++;
      if (first_scl == 0) first_scl = cyc;
      hw = 0;
    end
    if (scl_oe) hw++;
    if (!scl_oe && p_scl) begin
      if (hw < wmin) wmin = hw;
      if (hw > wmax) wmax = hw;
    end
    if (sda_oe && !p_sda) begin
      seen++;
      if (scl_oe) viol++;
    end
    if (!sda_oe && p_sda) begin
      last_fall = cyc;
      if (scl_oe) viol++;
    end
    if (done) begin
      ndone++;
      if (done_cyc == 0) done_cyc = cyc;
      if (p_done || busy) vdone++;
    end
    if (cyc == 1) begin busy1 = busy; pass1 = pass; end
    p_scl = scl_oe; p_sda = sda_oe; p_done = done;
  endtask

  task automatic run(input int k, input bit poke, input int exp_pass, input int exp_att);
    clr();
    k_stuck = k;
    start = 1'b1;
    tick();
    start = 1'b0;
    while (done_cyc == 0 && cyc < 6 * ATT) begin
      start = poke && (cyc >= 30 && cyc < 32);
      tick();
    end
    start = 1'b0;
    for (int j = 0; j < 12; j++) tick();
    check(busy1 == 1, "R2 busy after start", busy1, 1);
    check(pass1 == 0, "R2 pass cleared", pass1, 0);
    check(first_scl == S + U + 1, "R3 first clock low", first_scl, S + U + 1);
    check(wmin == U && wmax == U, "R3 clock low width", wmax, U);
    check(nscl == (P + 1) * exp_att, "R3 clock low count", nscl, (P + 1) * exp_att);
    check(seen == exp_att, "R6 attempt count", seen, exp_att);
    check(viol == 0, "R4 data edge with clock low", viol, 0);
    check(done_cyc - last_fall == U + 2, "R5 sample delay", done_cyc - last_fall, U + 2);
    check(done_cyc == 1 + exp_att * ATT, "R6 done latency", done_cyc, 1 + exp_att * ATT);
    check(int'(pass) == exp_pass, exp_pass ? "R5 pass" : "R7 fail reported", pass, exp_pass);
    check(ndone == 1 && vdone == 0, "R8 single done pulse", ndone, 1);
    if (poke) check(done_cyc == 1 + exp_att * ATT && ndone == 1, "R10 start while busy", ndone, 1);
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass, "R1 reset outputs", {busy, done, pass}, 0);
    check(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run(VEC[i][0], 1'b0, VEC[i][1], VEC[i][2]);

    // restart attempt mid-run
    run(2, 1'b1, 1, 3);

    // pass held while idle, lines released
    clr();
    k_stuck = 0;
    for (int j = 0; j < 20; j++) tick();
    check(pass == 1, "R9 pass held", pass, 1);
    check(!scl_oe && !sda_oe && nscl == 0, "R11 lines released idle", nscl, 0);

    run(9, 1'b0, 0, 4);
    for (int j = 0; j < 20; j++) tick();
    check(pass == 0, "R9 fail held", pass, 0);

    // reset during a run
    clr();
    k_stuck = 9;
    start = 1'b1; tick(); start = 1'b0;
    for (int j = 0; j < 100; j++) tick();
    rst_n = 1'b0;
    tick();
    check(!busy && !done && !pass && !scl_oe && !sda_oe, "R1 reset mid-run",
          {busy, done, pass, scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule